// File: doc/BRIEF.md
# Segmented Generalized Address Former

This block forms a two-part generalized address, a segment number with a word number, for every memory reference a processor makes. It keeps the processor state that addressing depends on: a procedure segment register, a program counter, eight index registers and four base pair registers. Each base pair register holds a complete segment/word pair. Simple write ports load these registers. The program counter also has a step input and a load input.

An instruction fetch takes its segment from the procedure segment register and its word number from the program counter. A data reference first forms an effective word offset from the instruction's address field plus an optional index register. When the reference is marked external, a 2-bit tag selects a base pair register. The address then takes that register's segment number, and its word number is the register's word number plus the effective offset. An internal data reference uses the procedure segment and the bare effective offset.

The result is registered. It appears one cycle after the request, together with a fetch/data kind bit and an out-of-range flag.

Top module: `gaddr_former`

## Requirements
- R1: After reset, every held register (procedure segment, program counter, index and base pair registers) is zero, and `addr_valid_o`, `addr_seg_o`, `addr_word_o`, `addr_kind_o` and `range_err_o` are all 0.
- R2: A request with `req_fetch_i`=1 yields, on the cycle after the request edge, `addr_valid_o`=1, `addr_kind_o`=1, `addr_seg_o` = procedure segment and `addr_word_o` = program counter, with `range_err_o`=0.
- R3: At a clock edge, `pc_load_i`=1 loads `pc_load_val_i` into the program counter even when `pc_step_i`=1. Otherwise `pc_step_i`=1 adds one, modulo 2^18.
- R4: A data request (`req_fetch_i`=0) with `req_ext_i`=0 yields `addr_kind_o`=0, the procedure segment and the effective offset as the word number, with `range_err_o`=0. `req_tag_i` has no effect in this case.
- R5: A data request with `req_ext_i`=1 uses base pair register `req_tag_i` (0 argument pointer, 1 base pointer, 2 linkage pointer, 3 stack pointer). The output segment is that register's segment. The output word number is its word number plus the effective offset, modulo 2^18.
- R6: When the addition in R5 carries out of bit 17, `range_err_o`=1 and the output segment is still the selected register's segment, unchanged.
- R7: The effective offset is `req_offs_i` plus an index term. `req_idx_i`=0 means no indexing, values 1 to 8 pick index registers 0 to 7, and values 9 to 15 add nothing.
- R8: The effective-offset addition wraps modulo 2^18 and never sets `range_err_o`.
- R9: On a cycle without a request, `addr_valid_o` is 0 and `addr_seg_o`, `addr_word_o`, `addr_kind_o` and `range_err_o` keep their previous values.
- R10: A register written at the same edge as a request is seen with its old value by that request and with its new value by later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pseg_we_i | input | 1 | Procedure segment register write enable |
| pseg_wdata_i | input | 14 | Procedure segment write value |
| pc_load_i | input | 1 | Program counter load (transfer of control) |
| pc_load_val_i | input | 18 | Program counter load value |
| pc_step_i | input | 1 | Program counter advance by one |
| xr_we_i | input | 1 | Index register write enable |
| xr_waddr_i | input | 3 | Index register write select |
| xr_wdata_i | input | 18 | Index register write value |
| bp_we_i | input | 1 | Base pair register write enable |
| bp_waddr_i | input | 2 | Base pair register write select |
| bp_wseg_i | input | 14 | Base pair segment write value |
| bp_wword_i | input | 18 | Base pair word write value |
| req_valid_i | input | 1 | Address request |
| req_fetch_i | input | 1 | 1 instruction fetch, 0 data reference |
| req_ext_i | input | 1 | External flag of a data reference |
| req_tag_i | input | 2 | Base pair select for an external reference |
| req_offs_i | input | 18 | Instruction address field |
| req_idx_i | input | 4 | Index select, 0 none, 1..8 index 0..7 |
| addr_valid_o | output | 1 | Address formed this cycle |
| addr_kind_o | output | 1 | 1 fetch, 0 data |
| addr_seg_o | output | 14 | Segment number |
| addr_word_o | output | 18 | Word number |
| range_err_o | output | 1 | Word addition carried past 2^18 |

## Verification
The assertions take the request inputs and write ports to be stable around the rising edge. They take reset to be asserted before the first edge, so that every `$past` term is defined. The bench drives all inputs on the falling edge and samples outputs on the next falling edge. Each request is therefore held for exactly one edge, and any write it is paired with lands at that same edge. Out-of-range index selects and carrying base words are produced on purpose, but only with defined (non-X) values.

// File: rtl/gaddr_pkg.sv
package gaddr_pkg;
  localparam int SEG_W_DEF  = 14;
  localparam int WORD_W_DEF = 18;
  localparam int NUM_X_DEF  = 8;
  localparam int NUM_BP_DEF = 4;

  typedef enum logic {
    KIND_DATA  = 1'b0,
    KIND_FETCH = 1'b1
  } ref_kind_e;

  // base pair roles, tag value order is architectural
  typedef enum logic [1:0] {
    BP_ARG   = 2'd0,
    BP_BASE  = 2'd1,
    BP_LINK  = 2'd2,
    BP_STACK = 2'd3
  } bp_role_e;
endpackage

// File: rtl/gaddr_pc.sv
module gaddr_pc #(
  parameter int WORD_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] load_val_i,
  input  logic              step_i,
  output logic [WORD_W-1:0] pc_o
);
  logic [WORD_W-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pc_q <= '0;
    else if (load_i) pc_q <= load_val_i;
    else if (step_i) pc_q <= pc_q + WORD_W'(1);
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/gaddr_xregs.sv
module gaddr_xregs #(
  parameter int WORD_W = 18,
  parameter int NUM_X  = 8,
  localparam int XA_W  = $clog2(NUM_X),
  localparam int SEL_W = $clog2(NUM_X + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [XA_W-1:0]   waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic [WORD_W-1:0] idx_val_o
);
  logic [WORD_W-1:0] x_q [NUM_X];

  for (genvar g = 0; g < NUM_X; g++) begin : g_x
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           x_q[g] <= '0;
      else if (we_i && waddr_i == XA_W'(g))  x_q[g] <= wdata_i;
    end
  end

  // select 0 and anything past NUM_X contribute nothing
  always_comb begin
    idx_val_o = '0;
    for (int i = 0; i < NUM_X; i++)
      if (sel_i == SEL_W'(i + 1)) idx_val_o = x_q[i];
  end
endmodule

// File: rtl/gaddr_bregs.sv
module gaddr_bregs #(
  parameter int SEG_W  = 14,
  parameter int WORD_W = 18,
  parameter int NUM_BP = 4,
  localparam int TAG_W = $clog2(NUM_BP)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [TAG_W-1:0]         waddr_i,
  input  logic [SEG_W-1:0]         wseg_i,
  input  logic [WORD_W-1:0]        wword_i,
  input  logic [TAG_W-1:0]         tag_i,
  output logic [SEG_W-1:0]         seg_o,
  output logic [WORD_W-1:0]        word_o,
  output logic [NUM_BP*SEG_W-1:0]  seg_flat_o
);
  logic [SEG_W-1:0]  seg_q  [NUM_BP];
  logic [WORD_W-1:0] word_q [NUM_BP];

  for (genvar g = 0; g < NUM_BP; g++) begin : g_bp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        seg_q[g]  <= '0;
        word_q[g] <= '0;
      end else if (we_i && waddr_i == TAG_W'(g)) begin
        seg_q[g]  <= wseg_i;
        word_q[g] <= wword_i;
      end
    end
    assign seg_flat_o[g*SEG_W +: SEG_W] = seg_q[g];
  end

  assign seg_o  = seg_q[tag_i];
  assign word_o = word_q[tag_i];
endmodule

// File: rtl/gaddr_calc.sv
module gaddr_calc #(
  parameter int SEG_W  = 14,
  parameter int WORD_W = 18
) (
  input  logic              fetch_i,
  input  logic              ext_i,
  input  logic [SEG_W-1:0]  pseg_i,
  input  logic [WORD_W-1:0] pc_i,
  input  logic [WORD_W-1:0] offs_i,
  input  logic [WORD_W-1:0] idx_val_i,
  input  logic [SEG_W-1:0]  bp_seg_i,
  input  logic [WORD_W-1:0] bp_word_i,
  output logic [SEG_W-1:0]  seg_o,
  output logic [WORD_W-1:0] word_o,
  output logic              carry_o
);
  logic [WORD_W-1:0] ea;
  logic [WORD_W:0]   based;

  assign ea    = offs_i + idx_val_i;  // wraps, no flag
  assign based = {1'b0, bp_word_i} + {1'b0, ea};

  always_comb begin
    if (fetch_i) begin
      seg_o   = pseg_i;
      word_o  = pc_i;
      carry_o = 1'b0;
    end else if (ext_i) begin
      seg_o   = bp_seg_i;
      word_o  = based[WORD_W-1:0];
      carry_o = based[WORD_W];
    end else begin
      seg_o   = pseg_i;
      word_o  = ea;
      carry_o = 1'b0;
    end
  end
endmodule

// File: rtl/gaddr_former.sv
module gaddr_former
  import gaddr_pkg::*;
#(
  parameter int SEG_W  = SEG_W_DEF,
  parameter int WORD_W = WORD_W_DEF,
  parameter int NUM_X  = NUM_X_DEF,
  parameter int NUM_BP = NUM_BP_DEF,
  localparam int XA_W  = $clog2(NUM_X),
  localparam int SEL_W = $clog2(NUM_X + 1),
  localparam int TAG_W = $clog2(NUM_BP)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pseg_we_i,
  input  logic [SEG_W-1:0]  pseg_wdata_i,
  input  logic              pc_load_i,
  input  logic [WORD_W-1:0] pc_load_val_i,
  input  logic              pc_step_i,
  input  logic              xr_we_i,
  input  logic [XA_W-1:0]   xr_waddr_i,
  input  logic [WORD_W-1:0] xr_wdata_i,
  input  logic              bp_we_i,
  input  logic [TAG_W-1:0]  bp_waddr_i,
  input  logic [SEG_W-1:0]  bp_wseg_i,
  input  logic [WORD_W-1:0] bp_wword_i,
  input  logic              req_valid_i,
  input  logic              req_fetch_i,
  input  logic              req_ext_i,
  input  logic [TAG_W-1:0]  req_tag_i,
  input  logic [WORD_W-1:0] req_offs_i,
  input  logic [SEL_W-1:0]  req_idx_i,
  output logic              addr_valid_o,
  output logic              addr_kind_o,
  output logic [SEG_W-1:0]  addr_seg_o,
  output logic [WORD_W-1:0] addr_word_o,
  output logic              range_err_o
);
  logic [SEG_W-1:0]        pseg_q;
  logic [WORD_W-1:0]       pc_q;
  logic [WORD_W-1:0]       idx_val;
  logic [SEG_W-1:0]        bp_seg;
  logic [WORD_W-1:0]       bp_word;
  logic [NUM_BP*SEG_W-1:0] bp_seg_flat;
  logic [SEG_W-1:0]        nxt_seg;
  logic [WORD_W-1:0]       nxt_word;
  logic                    nxt_carry;
  ref_kind_e               nxt_kind;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pseg_q <= '0;
    else if (pseg_we_i) pseg_q <= pseg_wdata_i;
  end

  gaddr_pc #(.WORD_W(WORD_W)) u_pc (
    .clk_i, .rst_ni,
    .load_i(pc_load_i), .load_val_i(pc_load_val_i), .step_i(pc_step_i),
    .pc_o(pc_q)
  );

  gaddr_xregs #(.WORD_W(WORD_W), .NUM_X(NUM_X)) u_xregs (
    .clk_i, .rst_ni,
    .we_i(xr_we_i), .waddr_i(xr_waddr_i), .wdata_i(xr_wdata_i),
    .sel_i(req_idx_i), .idx_val_o(idx_val)
  );

  gaddr_bregs #(.SEG_W(SEG_W), .WORD_W(WORD_W), .NUM_BP(NUM_BP)) u_bregs (
    .clk_i, .rst_ni,
    .we_i(bp_we_i), .waddr_i(bp_waddr_i), .wseg_i(bp_wseg_i), .wword_i(bp_wword_i),
    .tag_i(req_tag_i), .seg_o(bp_seg), .word_o(bp_word), .seg_flat_o(bp_seg_flat)
  );

  gaddr_calc #(.SEG_W(SEG_W), .WORD_W(WORD_W)) u_calc (
    .fetch_i(req_fetch_i), .ext_i(req_ext_i),
    .pseg_i(pseg_q), .pc_i(pc_q), .offs_i(req_offs_i), .idx_val_i(idx_val),
    .bp_seg_i(bp_seg), .bp_word_i(bp_word),
    .seg_o(nxt_seg), .word_o(nxt_word), .carry_o(nxt_carry)
  );

  assign nxt_kind = req_fetch_i ? KIND_FETCH : KIND_DATA;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_valid_o <= 1'b0;
      addr_kind_o  <= 1'b0;
      addr_seg_o   <= '0;
      addr_word_o  <= '0;
      range_err_o  <= 1'b0;
    end else begin
      addr_valid_o <= req_valid_i;
      if (req_valid_i) begin
        addr_kind_o <= nxt_kind;
        addr_seg_o  <= nxt_seg;
        addr_word_o <= nxt_word;
        range_err_o <= nxt_carry;
      end
    end
  end
endmodule

// File: rtl/gaddr_former_chk.sv
module gaddr_former_chk #(
  parameter int SEG_W  = 14,
  parameter int WORD_W = 18,
  parameter int NUM_BP = 4,
  localparam int TAG_W = $clog2(NUM_BP)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    req_valid_i,
  input logic                    req_fetch_i,
  input logic                    req_ext_i,
  input logic [TAG_W-1:0]        req_tag_i,
  input logic                    pc_load_i,
  input logic                    pc_step_i,
  input logic [WORD_W-1:0]       pc_load_val_i,
  input logic [WORD_W-1:0]       pc_q,
  input logic [SEG_W-1:0]        pseg_q,
  input logic [NUM_BP*SEG_W-1:0] bp_seg_flat,
  input logic                    addr_valid_o,
  input logic                    addr_kind_o,
  input logic [SEG_W-1:0]        addr_seg_o,
  input logic [WORD_W-1:0]       addr_word_o,
  input logic                    range_err_o
);
  logic [SEG_W-1:0] tag_seg;
  assign tag_seg = bp_seg_flat[SEG_W*int'(req_tag_i) +: SEG_W];

  p_fetch_pair_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_fetch_i |=> addr_valid_o && addr_kind_o
      && addr_seg_o == $past(pseg_q) && addr_word_o == $past(pc_q) && !range_err_o);

  p_pc_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_i |=> pc_q == $past(pc_load_val_i));

  p_pc_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pc_load_i && pc_step_i |=> pc_q == $past(pc_q) + WORD_W'(1));

  p_internal_seg_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !req_fetch_i && !req_ext_i |=> !addr_kind_o
      && addr_seg_o == $past(pseg_q) && !range_err_o);

  p_external_seg_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !req_fetch_i && req_ext_i |=> !addr_kind_o
      && addr_seg_o == $past(tag_seg));

  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !addr_valid_o && $stable(addr_seg_o) && $stable(addr_word_o)
      && $stable(range_err_o) && $stable(addr_kind_o));
endmodule

bind gaddr_former gaddr_former_chk #(
  .SEG_W(SEG_W), .WORD_W(WORD_W), .NUM_BP(NUM_BP)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .req_valid_i(req_valid_i), .req_fetch_i(req_fetch_i),
  .req_ext_i(req_ext_i), .req_tag_i(req_tag_i),
  .pc_load_i(pc_load_i), .pc_step_i(pc_step_i), .pc_load_val_i(pc_load_val_i),
  .pc_q(pc_q), .pseg_q(pseg_q), .bp_seg_flat(bp_seg_flat),
  .addr_valid_o(addr_valid_o), .addr_kind_o(addr_kind_o),
  .addr_seg_o(addr_seg_o), .addr_word_o(addr_word_o), .range_err_o(range_err_o)
);

// File: tb/sim_gaddr_former.sv
`timescale 1ns/1ps
module sim_gaddr_former;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pseg_we = 0;  logic [13:0] pseg_wdata = '0;
  logic        pc_load = 0;  logic [17:0] pc_load_val = '0; logic pc_step = 0;
  logic        xr_we = 0;    logic [2:0]  xr_waddr = '0;    logic [17:0] xr_wdata = '0;
  logic        bp_we = 0;    logic [1:0]  bp_waddr = '0;
  logic [13:0] bp_wseg = '0; logic [17:0] bp_wword = '0;
  logic        req_valid = 0, req_fetch = 0, req_ext = 0;
  logic [1:0]  req_tag = '0; logic [17:0] req_offs = '0; logic [3:0] req_idx = '0;
  logic        addr_valid, addr_kind, range_err;
  logic [13:0] addr_seg;     logic [17:0] addr_word;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [13:0] m_pseg; logic [17:0] m_pc;
  logic [17:0] m_x [8];
  logic [13:0] m_bs [4]; logic [17:0] m_bw [4];

  always #10 clk = ~clk;

  gaddr_former u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .pseg_we_i(pseg_we), .pseg_wdata_i(pseg_wdata),
    .pc_load_i(pc_load), .pc_load_val_i(pc_load_val), .pc_step_i(pc_step),
    .xr_we_i(xr_we), .xr_waddr_i(xr_waddr), .xr_wdata_i(xr_wdata),
    .bp_we_i(bp_we), .bp_waddr_i(bp_waddr), .bp_wseg_i(bp_wseg), .bp_wword_i(bp_wword),
    .req_valid_i(req_valid), .req_fetch_i(req_fetch), .req_ext_i(req_ext),
    .req_tag_i(req_tag), .req_offs_i(req_offs), .req_idx_i(req_idx),
    .addr_valid_o(addr_valid), .addr_kind_o(addr_kind),
    .addr_seg_o(addr_seg), .addr_word_o(addr_word), .range_err_o(range_err)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  function automatic logic [17:0] ea_of(input logic [17:0] o, input logic [3:0] s);
    logic [17:0] ix = (s >= 4'd1 && s <= 4'd8) ? m_x[s - 4'd1] : 18'd0;
    return o + ix;
  endfunction

  task automatic wr_pseg(input logic [13:0] v);
    @(negedge clk); pseg_we = 1; pseg_wdata = v;
    @(negedge clk); pseg_we = 0; m_pseg = v;
  endtask

  task automatic wr_x(input int i, input logic [17:0] v);
    @(negedge clk); xr_we = 1; xr_waddr = 3'(i); xr_wdata = v;
    @(negedge clk); xr_we = 0; m_x[i] = v;
  endtask

  task automatic wr_bp(input int i, input logic [13:0] s, input logic [17:0] w);
    @(negedge clk); bp_we = 1; bp_waddr = 2'(i); bp_wseg = s; bp_wword = w;
    @(negedge clk); bp_we = 0; m_bs[i] = s; m_bw[i] = w;
  endtask

  task automatic pc_op(input logic ld, input logic [17:0] v, input logic st);
    @(negedge clk); pc_load = ld; pc_load_val = v; pc_step = st;
    @(negedge clk); pc_load = 0; pc_step = 0;
    if (ld) m_pc = v; else if (st) m_pc = m_pc + 18'd1;
  endtask

  task automatic do_req(input logic f, input logic e, input logic [1:0] t,
                        input logic [17:0] o, input logic [3:0] s);
    @(negedge clk);
    req_valid = 1; req_fetch = f; req_ext = e; req_tag = t; req_offs = o; req_idx = s;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic t_reset;
    chk("R1 valid after reset", 32'(addr_valid), 0);
    chk("R1 seg after reset", 32'(addr_seg), 0);
    chk("R1 word after reset", 32'(addr_word), 0);
    chk("R1 err after reset", 32'(range_err), 0);
    do_req(1, 0, 0, 0, 0);
    chk("R1 fetch seg zero", 32'(addr_seg), 0);
    chk("R1 fetch pc zero", 32'(addr_word), 0);
    do_req(0, 1, 3, 18'h5, 4'd8);
    chk("R1 base and index zero", 32'(addr_word), 32'h5);
  endtask

  task automatic t_fetch;
    wr_pseg(14'h1ABC);
    pc_op(1, 18'h2_0040, 0);
    do_req(1, 0, 2, 18'h777, 4'd3);
    chk("R2 valid", 32'(addr_valid), 1);
    chk("R2 kind fetch", 32'(addr_kind), 1);
    chk("R2 seg", 32'(addr_seg), 32'(m_pseg));
    chk("R2 word", 32'(addr_word), 32'(m_pc));
    chk("R2 no err", 32'(range_err), 0);
  endtask

  task automatic t_pc;
    pc_op(0, 0, 1); pc_op(0, 0, 1); pc_op(0, 0, 1);
    do_req(1, 0, 0, 0, 0);
    chk("R3 step x3", 32'(addr_word), 32'h2_0043);
    pc_op(1, 18'h0_1000, 1);
    do_req(1, 0, 0, 0, 0);
    chk("R3 load beats step", 32'(addr_word), 32'h0_1000);
    pc_op(1, 18'h3_FFFF, 0);
    pc_op(0, 0, 1);
    do_req(1, 0, 0, 0, 0);
    chk("R3 step wrap", 32'(addr_word), 0);
  endtask

  task automatic t_index;
    for (int i = 0; i < 8; i++) wr_x(i, 18'(32'h100 * (i + 1) + i));
    do_req(0, 0, 0, 18'h10, 4'd0);
    chk("R7 sel 0 no index", 32'(addr_word), 32'h10);
    do_req(0, 0, 0, 18'h10, 4'd1);
    chk("R7 sel 1 X0", 32'(addr_word), 32'(ea_of(18'h10, 4'd1)));
    do_req(0, 0, 0, 18'h10, 4'd8);
    chk("R7 sel 8 X7", 32'(addr_word), 32'(ea_of(18'h10, 4'd8)));
    do_req(0, 0, 0, 18'h10, 4'd12);
    chk("R7 sel 12 none", 32'(addr_word), 32'h10);
  endtask

  task automatic t_internal;
    for (int t = 0; t < 4; t++) begin
      do_req(0, 0, 2'(t), 18'h321, 4'd4);
      chk("R4 kind data", 32'(addr_kind), 0);
      chk("R4 seg is procedure seg", 32'(addr_seg), 32'(m_pseg));
      chk("R4 word is ea, tag ignored", 32'(addr_word), 32'(ea_of(18'h321, 4'd4)));
      chk("R4 no err", 32'(range_err), 0);
    end
  endtask

  task automatic t_external;
    wr_bp(0, 14'h0011, 18'h0_1000);
    wr_bp(1, 14'h0222, 18'h0_2000);
    wr_bp(2, 14'h3333, 18'h1_0000);
    wr_bp(3, 14'h0044, 18'h3_0000);
    for (int t = 0; t < 4; t++) begin
      do_req(0, 1, 2'(t), 18'h40, 4'd2);
      chk("R5 seg from base pair", 32'(addr_seg), 32'(m_bs[t]));
      chk("R5 word sum", 32'(addr_word), 32'(m_bw[t] + ea_of(18'h40, 4'd2)));
      chk("R5 no err", 32'(range_err), 0);
    end
  endtask

  task automatic t_carry;
    wr_bp(3, 14'h0ACE, 18'h3_FFF0);
    do_req(0, 1, 3, 18'h20, 4'd0);
    chk("R6 err set", 32'(range_err), 1);
    chk("R6 word wrapped", 32'(addr_word), 32'h10);
    chk("R6 seg unchanged", 32'(addr_seg), 32'h0ACE);
    do_req(0, 1, 3, 18'hF, 4'd0);
    chk("R6 no carry at edge", 32'(range_err), 0);
    chk("R6 word max", 32'(addr_word), 32'h3_FFFF);
  endtask

  task automatic t_ea_wrap;
    wr_x(5, 18'h2);
    do_req(0, 0, 0, 18'h3_FFFF, 4'd6);
    chk("R8 ea wraps", 32'(addr_word), 1);
    chk("R8 no err on ea wrap", 32'(range_err), 0);
    wr_bp(0, 14'h0005, 18'h0_0003);
    do_req(0, 1, 0, 18'h3_FFFF, 4'd6);
    chk("R8 wrapped ea then based", 32'(addr_word), 4);
    chk("R8 based no carry", 32'(range_err), 0);
  endtask

  task automatic t_idle;
    do_req(0, 1, 3, 18'h20, 4'd0);
    @(negedge clk);
    chk("R9 valid low when idle", 32'(addr_valid), 0);
    chk("R9 seg held", 32'(addr_seg), 32'(m_bs[3]));
    chk("R9 err held", 32'(range_err), 1);
    chk("R9 kind held", 32'(addr_kind), 0);
  endtask

  task automatic t_same_edge;
    @(negedge clk);
    pseg_we = 1; pseg_wdata = 14'h2BAD;
    req_valid = 1; req_fetch = 1; req_ext = 0;
    @(negedge clk);
    pseg_we = 0; req_valid = 0;
    chk("R10 old seg on same edge", 32'(addr_seg), 32'(m_pseg));
    m_pseg = 14'h2BAD;
    do_req(1, 0, 0, 0, 0);
    chk("R10 new seg afterwards", 32'(addr_seg), 32'h2BAD);
  endtask

  initial begin
    m_pseg = '0; m_pc = '0;
    for (int i = 0; i < 8; i++) m_x[i] = '0;
    for (int i = 0; i < 4; i++) begin m_bs[i] = '0; m_bw[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_fetch;
    t_pc;
    t_index;
    t_internal;
    t_external;
    t_carry;
    t_ea_wrap;
    t_idle;
    t_same_edge;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule